// File: doc/BRIEF.md
# TDM Window Channel Selector

This block follows a time-division-multiplexed frame one serial bit clock at a time. It works out which channel slot the current bit belongs to and whether that slot's word should be moved. A frame sync pulse starts the frame. Each slot is a word of programmable length. The frame opens with a run of skipped slots, set by the window offset. The window follows: a programmable number of slots whose words may be transferred. A per-channel enable bitmap picks which window slots are actually active. The bitmap can be aligned in two ways. Its bit 0 can stand for absolute slot 0 of the frame. In offset-aligned mode, bit 0 stands instead for the first slot after the offset.

A 7-bit status count shows the channel currently being served. The block also gives a per-bit active flag for the current slot and a strobe on the last bit of every counted slot. A one-cycle frame-complete flag follows the final window slot, and the block then rests until the next frame sync. All configuration is captured at frame sync, so the configuration pins may change freely while a frame is in flight.

The control is a five-state machine:
- IDLE: the state after reset.
- SKIP: counting the offset slots.
- WINDOW: counting the window slots.
- DONE: the one-cycle frame-complete state.
- HOLD: resting until the next frame sync.

Its transitions are:
- Any state goes to SKIP on a frame sync with a non-zero offset, or to WINDOW on a frame sync with a zero offset.
- SKIP goes to WINDOW when the last offset slot ends.
- WINDOW goes to DONE when the last window slot ends.
- DONE goes to HOLD on the next clock.
- HOLD stays in HOLD until a frame sync arrives.

Top module: `tdm_window_sel`

## Requirements
- R1: After reset, chan_cnt is 0 and slot_active, word_strobe and frame_done are low, and they stay that way until the first frame sync.
- R2: A frame sync sampled high at a rising clock edge restarts the frame from any state, including mid-frame. The cycle after that edge is bit 0 of slot 0, and chan_cnt reads 0 in it.
- R3: Each slot lasts L clock cycles. L is word_len limited to the range 3 to 16: values below 3 act as 3 and values above 16 act as 16. word_strobe is high in the last cycle of every offset slot and every window slot.
- R4: With ofs_mode low, chan_cnt shows the absolute slot index modulo 128, counting 0 up to offset+size-1.
- R5: With ofs_mode high, chan_cnt counts 0 to offset-1 over the offset slots, then restarts at 0 for the first window slot and ends at size-1.
- R6: With ofs_mode low, chan_map bit i enables absolute slot i. Window slots whose absolute index is 32 or more are never active.
- R7: With ofs_mode high, chan_map bit i enables window slot i, counting from 0 at the first slot after the offset.
- R8: slot_active is low for every offset slot, whatever the bitmap holds. Within the window it is high for every bit of an enabled slot.
- R9: frame_done is high for exactly the one cycle after the last bit of the last window slot. From then until the next frame sync, chan_cnt holds its final value and word_strobe and slot_active stay low.
- R10: word_len, win_offset, win_size, ofs_mode and chan_map are sampled only at frame sync. Changing them during a frame does not change that frame's outputs.
- R11: A win_size of 0 acts as a one-slot window, and a win_size above 32 acts as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one cycle per data bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse, sampled on the rising edge |
| word_len | input | 5 | Bits per slot word (3 to 16 after limiting) |
| win_offset | input | 7 | Number of slots skipped before the window |
| win_size | input | 6 | Number of window slots (1 to 32 after limiting) |
| ofs_mode | input | 1 | 1: bitmap and count start after the offset; 0: absolute slots |
| chan_map | input | 32 | Per-channel enable bitmap |
| chan_cnt | output | 7 | Current channel status count |
| slot_active | output | 1 | Current slot's word is transferred |
| word_strobe | output | 1 | Last bit of the current counted slot |
| frame_done | output | 1 | One-cycle pulse after the last window slot |

## Verification
A slip in the bit counter shows at the ports within one slot. In that case, word_strobe lands off the L-cycle grid and chan_cnt steps a cycle early or late. A wrong slot or window counter shows at the next slot boundary. It appears as a skipped or repeated chan_cnt value, as slot_active following the wrong bitmap bit, or as frame_done firing at the wrong cycle. A state machine stuck in HOLD or DONE shows one cycle after frame sync, when chan_cnt should read 0 and strobes should begin. Because of this, the bench compares every output on every cycle of each frame and for several cycles after it.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    localparam int TDM_MAP_W   = 32;
    localparam int TDM_MAX_WIN = 32;
    localparam int TDM_CNT_W   = 7;
    localparam int TDM_OFF_W   = 7;
    localparam int TDM_LEN_W   = 5;
    localparam int TDM_MIN_LEN = 3;
    localparam int TDM_MAX_LEN = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SKIP   = 3'd1,
        ST_WINDOW = 3'd2,
        ST_DONE   = 3'd3,
        ST_HOLD   = 3'd4
    } slot_state_t;

endpackage

// File: rtl/tdm_cfg_latch.sv
// Captures the frame configuration at frame sync and limits it to legal ranges.
module tdm_cfg_latch #(
    parameter int LEN_W   = 5,
    parameter int OFF_W   = 7,
    parameter int SIZE_W  = 6,
    parameter int MAP_W   = 32,
    parameter int MIN_LEN = 3,
    parameter int MAX_LEN = 16,
    parameter int MAX_WIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [OFF_W-1:0]  win_offset,
    input  logic [SIZE_W-1:0] win_size,
    input  logic              ofs_mode,
    input  logic [MAP_W-1:0]  chan_map,
    output logic [LEN_W-1:0]  len_now,
    output logic [OFF_W-1:0]  off_now,
    output logic [LEN_W-1:0]  len_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [SIZE_W-1:0] size_q,
    output logic              mode_q,
    output logic [MAP_W-1:0]  map_q
);

    logic [SIZE_W-1:0] size_now;

    // Limit word length and window size to the supported ranges.
    always_comb begin
        if (word_len < LEN_W'(MIN_LEN)) begin
            len_now = LEN_W'(MIN_LEN);
        end else if (word_len > LEN_W'(MAX_LEN)) begin
            len_now = LEN_W'(MAX_LEN);
        end else begin
            len_now = word_len;
        end

        if (win_size == '0) begin
            size_now = SIZE_W'(1);
        end else if (win_size > SIZE_W'(MAX_WIN)) begin
            size_now = SIZE_W'(MAX_WIN);
        end else begin
            size_now = win_size;
        end

        off_now = win_offset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= LEN_W'(MIN_LEN);
            off_q  <= '0;
            size_q <= SIZE_W'(1);
            mode_q <= 1'b0;
            map_q  <= '0;
        end else if (fsync) begin
            len_q  <= len_now;
            off_q  <= off_now;
            size_q <= size_now;
            mode_q <= ofs_mode;
            map_q  <= chan_map;
        end
    end

endmodule

// File: rtl/tdm_bit_timer.sv
// Counts the bits of the current slot word and flags its last bit.
module tdm_bit_timer #(
    parameter int LEN_W = 5,
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_now,
    input  logic             run,
    input  logic [LEN_W-1:0] len_q,
    output logic             last_bit
);

    logic [BIT_W-1:0] bit_left;
    logic [BIT_W-1:0] reload_now;
    logic [BIT_W-1:0] reload_q;

    assign reload_now = BIT_W'(len_now - LEN_W'(1));
    assign reload_q   = BIT_W'(len_q - LEN_W'(1));
    assign last_bit   = run && (bit_left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_left <= '0;
        end else if (load) begin
            bit_left <= reload_now;
        end else if (run) begin
            if (bit_left == '0) begin
                bit_left <= reload_q;
            end else begin
                bit_left <= bit_left - BIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdm_slot_fsm.sv
// Frame sequencing: offset slots, window slots, completion and hold.
module tdm_slot_fsm
    import tdm_sel_pkg::*;
#(
    parameter int OFF_W  = 7,
    parameter int SIZE_W = 6,
    parameter int ABS_W  = 8,
    parameter int WIN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              last_bit,
    input  logic [OFF_W-1:0]  off_now,
    input  logic [OFF_W-1:0]  off_q,
    input  logic [SIZE_W-1:0] size_q,
    output slot_state_t       state,
    output logic [ABS_W-1:0]  abs_slot,
    output logic [WIN_W-1:0]  win_idx,
    output logic              run
);

    slot_state_t      state_d;
    logic [ABS_W-1:0] abs_d;
    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] win_last;

    assign win_last = WIN_W'(size_q - SIZE_W'(1));
    assign run      = (state == ST_SKIP) || (state == ST_WINDOW);

    always_comb begin
        state_d = state;
        abs_d   = abs_slot;
        win_d   = win_idx;
        if (fsync) begin
            abs_d   = '0;
            win_d   = '0;
            state_d = (off_now != '0) ? ST_WINDOW : ST_WINDOW;
            if (off_now != '0) begin
                state_d = ST_SKIP;
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_SKIP: begin
                    if (last_bit) begin
                        abs_d = abs_slot + ABS_W'(1);
                        if (abs_d == ABS_W'(off_q)) begin
                            state_d = ST_WINDOW;
                        end
                    end
                end
                ST_WINDOW: begin
                    if (last_bit) begin
                        if (win_idx == win_last) begin
                            state_d = ST_DONE;
                        end else begin
                            abs_d = abs_slot + ABS_W'(1);
                            win_d = win_idx + WIN_W'(1);
                        end
                    end
                end
                ST_DONE: begin
                    state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            abs_slot <= '0;
            win_idx  <= '0;
        end else begin
            state    <= state_d;
            abs_slot <= abs_d;
            win_idx  <= win_d;
        end
    end

endmodule

// File: rtl/tdm_chan_mask.sv
// Looks up the enable bit for the current slot in the captured bitmap.
module tdm_chan_mask #(
    parameter int MAP_W = 32,
    parameter int ABS_W = 8,
    parameter int WIN_W = 5
) (
    input  logic [MAP_W-1:0] map_q,
    input  logic             mode_q,
    input  logic [ABS_W-1:0] abs_slot,
    input  logic [WIN_W-1:0] win_idx,
    output logic             sel_bit
);

    logic [ABS_W-1:0] map_idx;
    logic [MAP_W-1:0] hit;

    assign map_idx = mode_q ? ABS_W'(win_idx) : abs_slot;

    // Decode the index against every bitmap position; indices past the map match nothing.
    for (genvar i = 0; i < MAP_W; i++) begin : g_hit
        assign hit[i] = map_q[i] && (map_idx == ABS_W'(i));
    end

    assign sel_bit = |hit;

endmodule

// File: rtl/tdm_window_sel.sv
module tdm_window_sel
    import tdm_sel_pkg::*;
#(
    parameter int MAP_W   = TDM_MAP_W,
    parameter int MAX_WIN = TDM_MAX_WIN,
    parameter int CNT_W   = TDM_CNT_W,
    parameter int OFF_W   = TDM_OFF_W,
    parameter int LEN_W   = TDM_LEN_W,
    parameter int MIN_LEN = TDM_MIN_LEN,
    parameter int MAX_LEN = TDM_MAX_LEN
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic [LEN_W-1:0]              word_len,
    input  logic [OFF_W-1:0]              win_offset,
    input  logic [$clog2(MAX_WIN+1)-1:0]  win_size,
    input  logic                          ofs_mode,
    input  logic [MAP_W-1:0]              chan_map,
    output logic [CNT_W-1:0]              chan_cnt,
    output logic                          slot_active,
    output logic                          word_strobe,
    output logic                          frame_done
);

    localparam int SIZE_W = $clog2(MAX_WIN + 1);
    localparam int WIN_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
    localparam int ABS_W  = $clog2((1 << OFF_W) + MAX_WIN);
    localparam int BIT_W  = $clog2(MAX_LEN);

    logic [LEN_W-1:0]  len_now;
    logic [OFF_W-1:0]  off_now;
    logic [LEN_W-1:0]  len_q;
    logic [OFF_W-1:0]  off_q;
    logic [SIZE_W-1:0] size_q;
    logic              mode_q;
    logic [MAP_W-1:0]  map_q;
    logic              last_bit;
    logic              run;
    slot_state_t       state;
    logic [ABS_W-1:0]  abs_slot;
    logic [WIN_W-1:0]  win_idx;
    logic              sel_bit;
    logic              past_skip;

    tdm_cfg_latch #(
        .LEN_W  (LEN_W),
        .OFF_W  (OFF_W),
        .SIZE_W (SIZE_W),
        .MAP_W  (MAP_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN),
        .MAX_WIN(MAX_WIN)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .word_len  (word_len),
        .win_offset(win_offset),
        .win_size  (win_size),
        .ofs_mode  (ofs_mode),
        .chan_map  (chan_map),
        .len_now   (len_now),
        .off_now   (off_now),
        .len_q     (len_q),
        .off_q     (off_q),
        .size_q    (size_q),
        .mode_q    (mode_q),
        .map_q     (map_q)
    );

    tdm_bit_timer #(
        .LEN_W(LEN_W),
        .BIT_W(BIT_W)
    ) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fsync),
        .len_now (len_now),
        .run     (run),
        .len_q   (len_q),
        .last_bit(last_bit)
    );

    tdm_slot_fsm #(
        .OFF_W (OFF_W),
        .SIZE_W(SIZE_W),
        .ABS_W (ABS_W),
        .WIN_W (WIN_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .last_bit(last_bit),
        .off_now (off_now),
        .off_q   (off_q),
        .size_q  (size_q),
        .state   (state),
        .abs_slot(abs_slot),
        .win_idx (win_idx),
        .run     (run)
    );

    tdm_chan_mask #(
        .MAP_W(MAP_W),
        .ABS_W(ABS_W),
        .WIN_W(WIN_W)
    ) u_mask (
        .map_q   (map_q),
        .mode_q  (mode_q),
        .abs_slot(abs_slot),
        .win_idx (win_idx),
        .sel_bit (sel_bit)
    );

    assign past_skip = (state == ST_WINDOW) || (state == ST_DONE) || (state == ST_HOLD);

    // Moore outputs from the sequencing state.
    always_comb begin
        if (mode_q && past_skip) begin
            chan_cnt = CNT_W'(win_idx);
        end else begin
            chan_cnt = CNT_W'(abs_slot);
        end
        slot_active = (state == ST_WINDOW) && sel_bit;
        word_strobe = last_bit;
        frame_done  = (state == ST_DONE);
    end

endmodule

// File: rtl/tdm_window_sel_chk.sv
module tdm_window_sel_chk
    import tdm_sel_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync,
    input logic [CNT_W-1:0] chan_cnt,
    input logic             slot_active,
    input logic             word_strobe,
    input logic             frame_done,
    input slot_state_t      state
);

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (chan_cnt == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !fsync) |=> ($stable(chan_cnt) && !word_strobe && !slot_active));

    // R8
    active_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_active |-> (state == ST_WINDOW));

    // R3
    strobe_when_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe |-> ((state == ST_SKIP) || (state == ST_WINDOW)));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && !fsync) |=>
            ((chan_cnt == $past(chan_cnt) + CNT_W'(1)) || (chan_cnt == '0) || frame_done));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!word_strobe && !slot_active && !frame_done && chan_cnt == '0));

endmodule

bind tdm_window_sel tdm_window_sel_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .chan_cnt   (chan_cnt),
    .slot_active(slot_active),
    .word_strobe(word_strobe),
    .frame_done (frame_done),
    .state      (state)
);

// File: tb/tdm_window_sel_test.sv
`timescale 1ns/1ps
module tdm_window_sel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [4:0]  word_len = 5'd3;
    logic [6:0]  win_offset = '0;
    logic [5:0]  win_size = 6'd1;
    logic        ofs_mode = 1'b0;
    logic [31:0] chan_map = '0;
    logic [6:0]  chan_cnt;
    logic        slot_active;
    logic        word_strobe;
    logic        frame_done;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tdm_window_sel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .word_len   (word_len),
        .win_offset (win_offset),
        .win_size   (win_size),
        .ofs_mode   (ofs_mode),
        .chan_map   (chan_map),
        .chan_cnt   (chan_cnt),
        .slot_active(slot_active),
        .word_strobe(word_strobe),
        .frame_done (frame_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pulses frame sync with the given configuration and compares every output each cycle.
    task automatic run_frame(input string req, input int len, input int off, input int size,
                             input bit mode, input logic [31:0] map, input bit scramble,
                             input int extra);
        int L = (len < 3) ? 3 : ((len > 16) ? 16 : len);
        int S = (size == 0) ? 1 : ((size > 32) ? 32 : size);
        int total = (off + S) * L;
        int last_cnt = mode ? (S - 1) : ((off + S - 1) % 128);
        @(negedge clk);
        word_len   = 5'(len);
        win_offset = 7'(off);
        win_size   = 6'(size);
        ofs_mode   = mode;
        chan_map   = map;
        fsync      = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        for (int c = 0; c < total + extra; c++) begin
            int ecnt, eact, estr, edone;
            if (c < total) begin
                int s = c / L;
                int b = c % L;
                bit inwin = (s >= off);
                int w = s - off;
                int idx = mode ? w : s;
                ecnt  = (mode && inwin) ? w : (s % 128);
                eact  = (inwin && idx < 32) ? int'(map[idx]) : 0;
                estr  = (b == L - 1) ? 1 : 0;
                edone = 0;
            end else begin
                ecnt  = last_cnt;
                eact  = 0;
                estr  = 0;
                edone = (c == total) ? 1 : 0;
            end
            chk(req, "chan_cnt", int'(chan_cnt), ecnt);
            chk(req, "slot_active", int'(slot_active), eact);
            chk(req, "word_strobe", int'(word_strobe), estr);
            chk(req, "frame_done", int'(frame_done), edone);
            if (scramble) begin
                word_len   = 5'(c * 7 + 1);
                win_offset = 7'(c * 3 + 5);
                win_size   = 6'(c + 2);
                ofs_mode   = ~ofs_mode;
                chan_map   = ~chan_map ^ 32'(c);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "chan_cnt in reset", int'(chan_cnt), 0);
        chk("R1", "frame_done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1", "chan_cnt idle", int'(chan_cnt), 0);
            chk("R1", "word_strobe idle", int'(word_strobe), 0);
            chk("R1", "slot_active idle", int'(slot_active), 0);
        end
    endtask

    task automatic t_normal_count;   // R4 R6 R3
        run_frame("R4", 3, 21, 8, 1'b0, 32'hA5A5_F00F, 1'b0, 3);
        run_frame("R6", 16, 21, 8, 1'b0, 32'h1234_5678, 1'b0, 3);
    endtask

    task automatic t_offset_count;   // R5 R7 R8
        run_frame("R5", 3, 21, 8, 1'b1, 32'hFFFF_FFB4, 1'b0, 3);
        run_frame("R7", 4, 0, 6, 1'b1, 32'h0000_0029, 1'b0, 2);
        run_frame("R8", 5, 4, 3, 1'b1, 32'hFFFF_FFFF, 1'b0, 2);
    endtask

    task automatic t_word_len;       // R3
        run_frame("R3", 2, 2, 3, 1'b0, 32'h0000_0014, 1'b0, 2);
        run_frame("R3", 20, 1, 2, 1'b1, 32'h0000_0001, 1'b0, 2);
    endtask

    task automatic t_map_edge;       // R6
        run_frame("R6", 3, 30, 4, 1'b0, 32'hFFFF_FFFF, 1'b0, 2);
    endtask

    task automatic t_restart;        // R2
        run_frame("R2", 4, 5, 6, 1'b0, 32'hFFFF_FFFF, 1'b0, -13);
        run_frame("R2", 3, 0, 2, 1'b0, 32'h0000_0002, 1'b0, 2);
    endtask

    task automatic t_config_hold;    // R10
        run_frame("R10", 6, 3, 5, 1'b1, 32'h0000_0015, 1'b1, 4);
    endtask

    task automatic t_size_limits;    // R11
        run_frame("R11", 3, 2, 0, 1'b0, 32'h0000_0004, 1'b0, 2);
        run_frame("R11", 3, 0, 40, 1'b1, 32'h8000_0001, 1'b0, 2);
    endtask

    task automatic t_hold;           // R9
        run_frame("R9", 3, 1, 2, 1'b0, 32'h0000_0006, 1'b0, 20);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_count();
        t_offset_count();
        t_word_len();
        t_map_edge();
        t_restart();
        t_config_hold();
        t_size_limits();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule